// File: doc/BRIEF.md
# Dual-Modulus Loop and Reference Divider

This block produces the two comparison-rate ticks for a frequency synthesizer's phase detector. The loop path divides the oscillator clock by a programmable ratio of 32·M + S. It does not use one wide binary counter. A small prescaler divides by either 32 or 33, and two slower counters steer it. A 13-bit main counter counts the prescaler periods in each output cycle. A 5-bit swallow counter decides how many of those periods use the longer 33-cycle modulus.

The reference path runs on the crystal clock. It applies a fixed halving stage and then a 13-bit programmable divider R, so its period is 2·R reference cycles. Each path emits a single-cycle pulse in its own clock domain whenever its counter chain reloads.

New ratio values are picked up only at those reload points. A power-save input freezes both chains. A synchronous reset reloads both chains from the current settings.

Top module: `pd_dual_divider`

## Requirements
- R1: With legal settings (32 ≤ M ≤ 8191, 0 ≤ S ≤ 31), consecutive `loop_pulse` assertions are exactly 32·M + S `clk_loop` cycles apart. For example, M=437 and S=16 give 14000.
- R2: In every output cycle, the first S prescaler periods last 33 cycles and the remaining M−S periods last 32 cycles. S=31 therefore lengthens the interval by exactly 31 cycles compared with S=0 at the same M.
- R3: For 2 ≤ R ≤ 8191, consecutive `ref_pulse` assertions are exactly 2·R `clk_ref` cycles apart. For example, R=1280 gives 2560.
- R4: `main_cnt`, `swallow_cnt` and `ref_cnt` are sampled only on the clock edge that raises the corresponding pulse. A change in the middle of an interval leaves that interval's length unchanged, and the new value governs the next interval.
- R5: While `sleep` is 1, both chains hold their state and both pulses stay 0. Each clock edge that sees `sleep` high lengthens the interval in progress by one cycle, and counting resumes where it stopped.
- R6: While `rst` is 1, both pulses are 0 and both chains reload from the ports. After release, the first `loop_pulse` comes on the 32·M+S-th `clk_loop` edge with `rst` low, and the first `ref_pulse` comes on the 2·R-th `clk_ref` edge with `rst` low.
- R7: Each pulse is high for exactly one cycle of its own clock.
- R8: The smallest settings work. M=32 with S=0 gives 1024 cycles, and R=2 gives 4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_loop | input | 1 | Oscillator-side clock being divided |
| clk_ref | input | 1 | Crystal-side reference clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| sleep | input | 1 | Power-save; 1 freezes both counter chains |
| main_cnt | input | 13 | Main count M |
| swallow_cnt | input | 5 | Swallow count S |
| ref_cnt | input | 13 | Reference count R |
| loop_pulse | output | 1 | One-cycle pulse per 32·M+S loop cycles |
| ref_pulse | output | 1 | One-cycle pulse per 2·R reference cycles |

## Verification
A loop pulse is due exactly 32·M+S rising edges after the previous one. A reference pulse is due 2·R edges after the previous one. After reset, each first pulse is due that many edges after the first edge that sees reset low. Every edge that samples `sleep` high pushes the due edge one later.

The monitors sample one fraction of a cycle after each rising edge of their own clock. They count edges since the last pulse and add the sleeping edges they observed. They compare the total with the figure the driver queued when that interval began. The driver changes settings only at the opposite clock edge, so the value that is queued is always the one the design latched on the pulse edge.

// File: rtl/pd_div_pkg.sv
package pd_div_pkg;

  typedef enum logic {
    MOD_LOW  = 1'b0,
    MOD_HIGH = 1'b1
  } pd_mod_e;

  localparam int PD_PRE_BITS = 5;
  localparam int PD_M_BITS   = 13;
  localparam int PD_R_BITS   = 13;

endpackage

// File: rtl/pd_prescaler.sv
module pd_prescaler
  import pd_div_pkg::*;
#(
  parameter int PRE_BITS = PD_PRE_BITS
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    run,
  input  pd_mod_e mode,
  output logic    carry
);

  localparam int P  = 1 << PRE_BITS;
  localparam int CW = PRE_BITS + 1;

  logic [CW-1:0] pc;
  logic [CW-1:0] top;

  always_comb top = (mode == MOD_HIGH) ? CW'(P) : CW'(P - 1);
  always_comb carry = run && (pc == top);

  always_ff @(posedge clk) begin
    if (rst)        pc <= '0;
    else if (run)   pc <= carry ? '0 : pc + 1'b1;
  end

  // R5: frozen while in power-save
  p_presc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pc));

  // R2: count never passes the longer modulus
  p_presc_range_r2: assert property (@(posedge clk) disable iff (rst)
    pc <= CW'(P));

  // R6: reset clears the prescaler
  p_presc_clear_r6: assert property (@(posedge clk)
    rst |=> pc == '0);

endmodule

// File: rtl/pd_swallow_main.sv
module pd_swallow_main
  import pd_div_pkg::*;
#(
  parameter int PRE_BITS = PD_PRE_BITS,
  parameter int M_BITS   = PD_M_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                carry,
  input  logic [M_BITS-1:0]   m_in,
  input  logic [PRE_BITS-1:0] s_in,
  output pd_mod_e             mode,
  output logic                pulse
);

  logic [M_BITS-1:0]   mc;
  logic [PRE_BITS-1:0] sc;
  logic                last;

  always_comb mode = (sc != '0) ? MOD_HIGH : MOD_LOW;
  always_comb last = (mc == M_BITS'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mc    <= m_in;
      sc    <= s_in;
      pulse <= 1'b0;
    end else if (run && carry) begin
      if (last) begin
        mc    <= m_in;
        sc    <= s_in;
        pulse <= 1'b1;
      end else begin
        mc    <= mc - 1'b1;
        if (sc != '0) sc <= sc - 1'b1;
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end

  // R7: single-cycle output
  p_loop_single_r7: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R5: no output while sleeping
  p_loop_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pulse);

  // R4: settings are taken on the pulse edge
  p_loop_reload_r4: assert property (@(posedge clk) disable iff (rst)
    pulse |-> (mc == $past(m_in)) && (sc == $past(s_in)));

endmodule

// File: rtl/pd_ref_div.sv
module pd_ref_div
  import pd_div_pkg::*;
#(
  parameter int R_BITS = PD_R_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [R_BITS-1:0] r_in,
  output logic              pulse
);

  logic              half;
  logic [R_BITS-1:0] rc;
  logic              tick;

  always_comb tick = run && half;

  always_ff @(posedge clk) begin
    if (rst) begin
      half  <= 1'b0;
      rc    <= r_in;
      pulse <= 1'b0;
    end else begin
      if (run) half <= ~half;
      if (tick) begin
        if (rc == R_BITS'(1)) begin
          rc    <= r_in;
          pulse <= 1'b1;
        end else begin
          rc    <= rc - 1'b1;
          pulse <= 1'b0;
        end
      end else begin
        pulse <= 1'b0;
      end
    end
  end

  // R7: single-cycle output
  p_ref_single_r7: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R5: frozen and silent while sleeping
  p_ref_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(half) && $stable(rc) && !pulse);

  // R4: reference setting taken on the pulse edge
  p_ref_reload_r4: assert property (@(posedge clk) disable iff (rst)
    pulse |-> rc == $past(r_in));

endmodule

// File: rtl/pd_dual_divider.sv
module pd_dual_divider
  import pd_div_pkg::*;
#(
  parameter int PRE_BITS = PD_PRE_BITS,
  parameter int M_BITS   = PD_M_BITS,
  parameter int R_BITS   = PD_R_BITS
) (
  input  logic                clk_loop,
  input  logic                clk_ref,
  input  logic                rst,
  input  logic                sleep,
  input  logic [M_BITS-1:0]   main_cnt,
  input  logic [PRE_BITS-1:0] swallow_cnt,
  input  logic [R_BITS-1:0]   ref_cnt,
  output logic                loop_pulse,
  output logic                ref_pulse
);

  logic    run;
  logic    carry;
  pd_mod_e mode;

  always_comb run = ~sleep;

  pd_prescaler #(.PRE_BITS(PRE_BITS)) u_presc (
    .clk   (clk_loop),
    .rst   (rst),
    .run   (run),
    .mode  (mode),
    .carry (carry)
  );

  pd_swallow_main #(.PRE_BITS(PRE_BITS), .M_BITS(M_BITS)) u_ctrl (
    .clk   (clk_loop),
    .rst   (rst),
    .run   (run),
    .carry (carry),
    .m_in  (main_cnt),
    .s_in  (swallow_cnt),
    .mode  (mode),
    .pulse (loop_pulse)
  );

  pd_ref_div #(.R_BITS(R_BITS)) u_ref (
    .clk   (clk_ref),
    .rst   (rst),
    .run   (run),
    .r_in  (ref_cnt),
    .pulse (ref_pulse)
  );

endmodule

// File: tb/pd_dual_divider_tb.sv
`timescale 1ns/100ps
module pd_dual_divider_tb;

  typedef struct {
    int    cycles;
    string req;
  } exp_t;

  logic        clk_loop = 1'b0;
  logic        clk_ref  = 1'b0;
  logic        rst      = 1'b1;
  logic        sleep    = 1'b0;
  logic [12:0] main_cnt    = 13'd32;
  logic [4:0]  swallow_cnt = 5'd0;
  logic [12:0] ref_cnt     = 13'd2;
  logic        loop_pulse, ref_pulse;

  int    checks = 0;
  int    errors = 0;
  bit    loop_done = 0;
  bit    ref_done  = 0;
  string loop_tag  = "R8";
  string ref_tag   = "R8";
  exp_t  loop_q[$];
  exp_t  ref_q[$];

  always #2.5 clk_loop = ~clk_loop;
  initial begin
    #1.5;
    forever #4 clk_ref = ~clk_ref;
  end

  pd_dual_divider u_dut (
    .clk_loop    (clk_loop),
    .clk_ref     (clk_ref),
    .rst         (rst),
    .sleep       (sleep),
    .main_cnt    (main_cnt),
    .swallow_cnt (swallow_cnt),
    .ref_cnt     (ref_cnt),
    .loop_pulse  (loop_pulse),
    .ref_pulse   (ref_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_loop_pulse();
    do @(negedge clk_loop); while (!loop_pulse);
  endtask

  task automatic wait_ref_pulse();
    do @(negedge clk_ref); while (!ref_pulse);
  endtask

  // at a loop pulse: queue the interval now starting, then set next values
  task automatic loop_step(input int m, input int s, input string tag);
    loop_q.push_back(exp_t'{32 * int'(main_cnt) + int'(swallow_cnt), loop_tag});
    main_cnt    = 13'(m);
    swallow_cnt = 5'(s);
    loop_tag    = tag;
    wait_loop_pulse();
  endtask

  task automatic ref_step(input int r, input string tag);
    ref_q.push_back(exp_t'{2 * int'(ref_cnt), ref_tag});
    ref_cnt = 13'(r);
    ref_tag = tag;
    wait_ref_pulse();
  endtask

  // loop-side driver
  initial begin
    int n;
    repeat (20) @(negedge clk_loop);
    check("R6 loop_pulse in reset", int'(loop_pulse), 0);
    check("R6 ref_pulse in reset", int'(ref_pulse), 0);
    rst = 1'b0;
    @(posedge clk_loop);
    n = 0;
    do begin
      @(negedge clk_loop);
      n++;
    end while (!loop_pulse && n < 5000);
    check("R6 first loop pulse", n, 1024);
    loop_step(32, 31, "R2");
    loop_step(32, 31, "R2");
    loop_step(437, 16, "R1");
    loop_step(33, 17, "R1");
    loop_step(33, 17, "R1");
    // R4: change mid-interval, current interval keeps 33/17
    loop_q.push_back(exp_t'{1073, "R4"});
    repeat (300) @(negedge clk_loop);
    main_cnt    = 13'd40;
    swallow_cnt = 5'd5;
    loop_tag    = "R4";
    wait_loop_pulse();
    // R5: sleep inside an interval
    loop_q.push_back(exp_t'{1285, "R5"});
    loop_tag = "R1";
    repeat (100) @(negedge clk_loop);
    sleep = 1'b1;
    repeat (50) @(negedge clk_loop);
    sleep = 1'b0;
    wait_loop_pulse();
    loop_step(40, 5, "R1");
    loop_done = 1;
    while (!ref_done) loop_step(40, 5, "R1");
  end

  // reference-side driver
  initial begin
    int n;
    @(negedge rst);
    @(posedge clk_ref);
    n = 0;
    do begin
      @(negedge clk_ref);
      n++;
    end while (!ref_pulse && n < 5000);
    check("R6 first ref pulse", n, 4);
    ref_step(2, "R8");
    ref_step(3, "R3");
    ref_step(3, "R3");
    ref_step(1280, "R3");
    ref_step(8191, "R3");
    ref_step(2, "R8");
    ref_done = 1;
    while (!loop_done) ref_step(2, "R8");
  end

  // loop monitor
  initial begin : mon_loop
    int   cnt;
    int   slp;
    bit   armed;
    bit   prev;
    exp_t e;
    cnt = 0; slp = 0; armed = 0; prev = 0;
    forever begin
      @(posedge clk_loop);
      #1;
      if (rst) begin
        armed = 0; prev = 0; loop_q.delete();
      end else begin
        if (prev) check("R7 loop pulse width", int'(loop_pulse), 0);
        if (loop_pulse) begin
          if (armed && loop_q.size() > 0) begin
            e = loop_q.pop_front();
            check({e.req, " loop interval"}, cnt, e.cycles + slp);
          end
          armed = 1; cnt = 1; slp = 0;
        end else begin
          cnt++;
          if (sleep) slp++;
        end
        prev = loop_pulse;
      end
    end
  end

  // reference monitor
  initial begin : mon_ref
    int   cnt;
    int   slp;
    bit   armed;
    bit   prev;
    exp_t e;
    cnt = 0; slp = 0; armed = 0; prev = 0;
    forever begin
      @(posedge clk_ref);
      #0.2;
      if (rst) begin
        armed = 0; prev = 0; ref_q.delete();
      end else begin
        if (prev) check("R7 ref pulse width", int'(ref_pulse), 0);
        if (ref_pulse) begin
          if (armed && ref_q.size() > 0) begin
            e = ref_q.pop_front();
            check({e.req, " ref interval"}, cnt, e.cycles + slp);
          end
          armed = 1; cnt = 1; slp = 0;
        end else begin
          cnt++;
          if (sleep) slp++;
        end
        prev = ref_pulse;
      end
    end
  end

  // completion
  initial begin
    wait (loop_done && ref_done);
    repeat (10) @(negedge clk_loop);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_loop);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule